// File: doc/BRIEF.md
# Configuration Window Router

This block sits behind a memory-mapped address window and turns each host load or store that lands in the window into a configuration access. The window base is masked and then subtracted from the request address. The resulting offset is split into a device number, a function number and a register offset. Together, the device and function numbers select one slot in a table of up to 32 devices with 8 functions each. A presence vector says which slots hold a real function.

Accesses to populated slots are passed to a shared forward port with their register offset, byte count and write data, using a valid/ready handshake. An absent slot, an illegal byte count, or an offset that falls outside the window is answered by the router itself. Every access ends with a one-cycle response that arrives a programmable number of cycles after the access is resolved. Only one access is in flight at a time.

After reset, the router also walks the populated slots once and raises a sticky flag if two of them report the same interrupt line number.

Top module: `cfg_window_router`

## Requirements
- R1: The offset is `req_addr - (win_base & win_mask)`. Offset bits [15:11] are the device and bits [10:8] the function. The forwarded slot index is {device, function}, and the forwarded register is offset bits [7:0].
- R2: A read or write to a present slot with a legal size raises `fwd_valid`. It carries the register, the byte count, the write flag and the unmodified write data, and holds them stable until `fwd_ready`.
- R3: A read of an absent slot is not forwarded. It responds with `rsp_err`=0 and all ones right-aligned to the width: 0xFF, 0xFFFF or 0xFFFFFFFF for 1, 2 or 4 bytes.
- R4: A write to an absent slot is not forwarded. It responds with `rsp_err`=1 and `rsp_rdata`=0.
- R5: A byte count `req_size` other than 1, 2 or 4 gives `rsp_err`=1 and `rsp_rdata`=0 for reads and writes, and nothing is forwarded.
- R6: `rsp_valid` is a one-cycle pulse that comes `rsp_latency` cycles after the acceptance edge (answered locally) or after the forward handshake edge. A latency of 0 behaves as 1.
- R7: Forwarded read data is `fwd_rdata` masked to the access width, right-aligned. A forwarded write responds with data 0 and no error.
- R8: `req_ready` falls after acceptance and rises again only after the response cycle. A second request is never taken while one is in flight.
- R9: After reset, `irq_scan_done` rises 256 cycles later. `irq_dup` is then 1 exactly when two present slots share an interrupt line; lines of absent slots are ignored.
- R10: In reset, `req_ready`, `rsp_valid`, `fwd_valid`, `irq_scan_done` and `irq_dup` are all 0.
- R11: An offset with any bit above bit 15 set, including an address below the base, responds with `rsp_err`=1 and is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | 32 | Window base address |
| win_mask | input | 32 | Mask applied to the base before subtraction |
| rsp_latency | input | 8 | Response delay in cycles (0 acts as 1) |
| slot_present | input | 256 | Presence bit per slot, index {device, function} |
| slot_irq_line | input | 2048 | 8-bit interrupt line per slot, slot i at bits [8i+7:8i] |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Router idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_size | input | 3 | Byte count |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 32 | Read data, right-aligned |
| fwd_valid | output | 1 | Forwarded access valid |
| fwd_ready | input | 1 | Slot accepts the forwarded access |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_slot | output | 8 | Target slot {device, function} |
| fwd_reg | output | 8 | Register offset |
| fwd_size | output | 3 | Byte count |
| fwd_wdata | output | 32 | Write data |
| fwd_rdata | input | 32 | Slot read data, valid with fwd_ready |
| irq_scan_done | output | 1 | Interrupt-line scan finished |
| irq_dup | output | 1 | Two present slots share an interrupt line |

## Verification
The bench uses a base address with low bits that the mask must remove. A design that forgot the mask would compute every offset wrongly, so slot and register numbers would be off. Reads of absent slots at each of the three widths catch a router that always returns 32 ones, or that forwards to a missing slot. Writes to absent slots, byte counts of 0, 3 and 5, and addresses above and below the window catch a router that forwards or answers without error. Response timing is measured against the acceptance or handshake edge at latencies 0, 1 and 3, with a stalled forward port. The scan runs with an absent slot that carries a clashing line, so a scan that ignored presence would raise a false duplicate.

// File: rtl/cfg_window_router.sv
module cfg_window_router #(
  parameter int ADDR_W = 32,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 8,
  parameter int DATA_W = 32,
  parameter int SZ_W   = 3,
  parameter int LAT_W  = 8,
  parameter int IRQ_W  = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [ADDR_W-1:0]                        win_base,
  input  logic [ADDR_W-1:0]                        win_mask,
  input  logic [LAT_W-1:0]                         rsp_latency,
  input  logic [(1<<(DEV_W+FN_W))-1:0]             slot_present,
  input  logic [(1<<(DEV_W+FN_W))*IRQ_W-1:0]       slot_irq_line,
  input  logic                                     req_valid,
  output logic                                     req_ready,
  input  logic                                     req_write,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [SZ_W-1:0]                          req_size,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     rsp_valid,
  output logic                                     rsp_err,
  output logic [DATA_W-1:0]                        rsp_rdata,
  output logic                                     fwd_valid,
  input  logic                                     fwd_ready,
  output logic                                     fwd_write,
  output logic [DEV_W+FN_W-1:0]                    fwd_slot,
  output logic [REG_W-1:0]                         fwd_reg,
  output logic [SZ_W-1:0]                          fwd_size,
  output logic [DATA_W-1:0]                        fwd_wdata,
  input  logic [DATA_W-1:0]                        fwd_rdata,
  output logic                                     irq_scan_done,
  output logic                                     irq_dup
);
  localparam int SLOT_W = DEV_W + FN_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int OFF_W  = REG_W + SLOT_W;
  localparam int NLINE  = 1 << IRQ_W;

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RESP} state_t;

  function automatic logic [DATA_W-1:0] width_mask(input logic [SZ_W-1:0] s);
    if (s == SZ_W'(1))      width_mask = DATA_W'(8'hFF);
    else if (s == SZ_W'(2)) width_mask = DATA_W'(16'hFFFF);
    else                    width_mask = '1;
  endfunction

  state_t              state;
  logic [LAT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   offset;
  logic [SLOT_W-1:0]   in_slot;
  logic                in_range, in_hit, size_ok, accept;
  logic [LAT_W-1:0]    lat_eff;

  assign offset   = req_addr - (win_base & win_mask);
  assign in_slot  = offset[REG_W +: SLOT_W];
  assign in_range = (offset >> OFF_W) == '0;
  assign in_hit   = slot_present[in_slot];
  assign size_ok  = (req_size == SZ_W'(1)) || (req_size == SZ_W'(2)) || (req_size == SZ_W'(4));
  assign lat_eff  = (rsp_latency == '0) ? LAT_W'(1) : rsp_latency;

  assign req_ready = rst_n && (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign fwd_valid = (state == S_FWD);
  assign rsp_valid = (state == S_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      fwd_write <= 1'b0;
      fwd_slot  <= '0;
      fwd_reg   <= '0;
      fwd_size  <= '0;
      fwd_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          fwd_write <= req_write;
          fwd_slot  <= in_slot;
          fwd_reg   <= offset[REG_W-1:0];
          fwd_size  <= req_size;
          fwd_wdata <= req_wdata;
          cnt       <= lat_eff;
          if (!size_ok || !in_range || (req_write && !in_hit)) begin
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            state     <= S_WAIT;
          end else if (!in_hit) begin
            rsp_err   <= 1'b0;
            rsp_rdata <= width_mask(req_size);
            state     <= S_WAIT;
          end else begin
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            state     <= S_FWD;
          end
        end
        S_FWD: if (fwd_ready) begin
          rsp_rdata <= fwd_write ? '0 : (fwd_rdata & width_mask(fwd_size));
          cnt       <= lat_eff;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt <= LAT_W'(1)) state <= S_RESP;
          else                  cnt   <= cnt - LAT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [SLOT_W-1:0] scan_idx;
  logic [NLINE-1:0]  seen;
  logic [IRQ_W-1:0]  scan_line;

  assign scan_line = slot_irq_line[scan_idx*IRQ_W +: IRQ_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_idx      <= '0;
      seen          <= '0;
      irq_dup       <= 1'b0;
      irq_scan_done <= 1'b0;
    end else if (!irq_scan_done) begin
      if (slot_present[scan_idx]) begin
        if (seen[scan_line]) irq_dup <= 1'b1;
        seen[scan_line] <= 1'b1;
      end
      scan_idx <= scan_idx + SLOT_W'(1);
      if (scan_idx == SLOT_W'(NSLOT-1)) irq_scan_done <= 1'b1;
    end
  end

  p_fwd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_slot) && $stable(fwd_reg)
                                && $stable(fwd_size) && $stable(fwd_write) && $stable(fwd_wdata));
  p_fwd_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> slot_present[fwd_slot]);
  p_fwd_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_size == SZ_W'(1) || fwd_size == SZ_W'(2) || fwd_size == SZ_W'(4)));
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_busy_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !req_ready && !rsp_valid);
  p_scan_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_scan_done |=> irq_scan_done && $stable(irq_dup));
endmodule

// File: tb/tb_cfg_window_router.sv
module tb_cfg_window_router;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [31:0]   win_base, win_mask;
  logic [7:0]    rsp_latency;
  logic [255:0]  slot_present;
  logic [2047:0] slot_irq_line;
  logic          req_valid, req_ready, req_write;
  logic [31:0]   req_addr, req_wdata;
  logic [2:0]    req_size;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic          fwd_valid, fwd_ready, fwd_write;
  logic [7:0]    fwd_slot, fwd_reg;
  logic [2:0]    fwd_size;
  logic [31:0]   fwd_wdata, fwd_rdata;
  logic          irq_scan_done, irq_dup;

  cfg_window_router dut (.*);

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic        o_fseen, o_fwr, o_got, o_err, o_busy, o_idle_after;
  logic [7:0]  o_fslot, o_freg;
  logic [2:0]  o_fsize;
  logic [31:0] o_fwd_wd, o_rd;
  int          o_lat;

  function automatic logic [31:0] cfg_addr(input int dev, input int fn, input int rg);
    return 32'h8A00_0000 + 32'((dev << 11) | (fn << 8) | rg);
  endfunction

  function automatic int exp_lat();
    return (rsp_latency == 0) ? 1 : int'(rsp_latency);
  endfunction

  task automatic access(input logic wr, input logic [31:0] addr, input logic [2:0] sz,
                        input logic [31:0] wd, input int dly);
    int e, ref_e, waited;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    o_busy = !req_ready;
    e = 0; ref_e = 0; waited = 0; o_fseen = 0; o_got = 0;
    for (int k = 0; k < 300 && !o_got; k++) begin
      if (rsp_valid) begin
        o_got = 1; o_rd = rsp_rdata; o_err = rsp_err; o_lat = e - ref_e;
      end else begin
        fwd_ready = 1'b0;
        if (fwd_valid) begin
          o_fseen = 1; o_fslot = fwd_slot; o_freg = fwd_reg; o_fsize = fwd_size;
          o_fwr = fwd_write; o_fwd_wd = fwd_wdata;
          if (waited >= dly) begin
            fwd_ready = 1'b1;
            fwd_rdata = {8'h5A, fwd_slot, fwd_reg, 8'hC3};
            ref_e = e + 1;
          end
          waited++;
        end
        @(posedge clk);
        e++;
        @(negedge clk);
      end
    end
    fwd_ready = 1'b0;
    @(negedge clk);
    o_idle_after = req_ready;
  endtask

  task automatic do_reset(input logic [7:0] line255);
    rst_n = 1'b0;
    slot_present = '0;
    slot_irq_line = '0;
    slot_present[24] = 1'b1;  slot_irq_line[24*8 +: 8]  = 8'd5;
    slot_present[25] = 1'b1;  slot_irq_line[25*8 +: 8]  = 8'd6;
    slot_present[141] = 1'b1; slot_irq_line[141*8 +: 8] = 8'd9;
    slot_present[255] = 1'b1; slot_irq_line[255*8 +: 8] = line255;
    slot_irq_line[0 +: 8] = 8'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_scan(input logic [7:0] line255, input logic dup_exp);
    do_reset(line255);
    check(!req_ready && !rsp_valid && !fwd_valid, "R10 outputs idle in reset",
          {29'd0, req_ready, rsp_valid, fwd_valid}, 32'd0);
    check(!irq_scan_done && !irq_dup, "R10 scan flags low in reset",
          {30'd0, irq_scan_done, irq_dup}, 32'd0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check(!irq_scan_done, "R9 scan not done early", {31'd0, irq_scan_done}, 32'd0);
    repeat (200) @(negedge clk);
    check(irq_scan_done, "R9 scan done", {31'd0, irq_scan_done}, 32'd1);
    check(irq_dup == dup_exp, "R9 duplicate flag", {31'd0, irq_dup}, {31'd0, dup_exp});
  endtask

  task automatic t_fwd_read(input int dev, input int fn, input int rg, input logic [2:0] sz, input int dly);
    logic [7:0] sl;
    logic [31:0] full, expd;
    sl = 8'(dev * 8 + fn);
    full = {8'h5A, sl, 8'(rg), 8'hC3};
    expd = (sz == 1) ? (full & 32'hFF) : (sz == 2) ? (full & 32'hFFFF) : full;
    access(1'b0, cfg_addr(dev, fn, rg), sz, 32'h0, dly);
    check(o_fseen && o_fslot == sl, "R1 forwarded slot", {24'd0, o_fslot}, {24'd0, sl});
    check(o_freg == 8'(rg), "R1 forwarded register", {24'd0, o_freg}, rg);
    check(o_fsize == sz && !o_fwr, "R2 forwarded size and read flag", {28'd0, o_fwr, o_fsize}, {29'd0, sz});
    check(o_got && !o_err && o_rd == expd, "R7 masked read data", o_rd, expd);
    check(o_lat == exp_lat(), "R6 latency after handshake", o_lat, exp_lat());
    check(o_busy && o_idle_after, "R8 busy then idle", {30'd0, o_busy, o_idle_after}, 32'd3);
  endtask

  task automatic t_fwd_write();
    access(1'b1, cfg_addr(31, 7, 8'h10), 3'd4, 32'hDEAD_BEEF, 1);
    check(o_fseen && o_fwr && o_fslot == 8'hFF && o_freg == 8'h10, "R2 write forwarded",
          {o_fwr, 15'd0, o_fslot, o_freg}, {1'b1, 15'd0, 8'hFF, 8'h10});
    check(o_fwd_wd == 32'hDEAD_BEEF, "R2 write data", o_fwd_wd, 32'hDEAD_BEEF);
    check(o_got && !o_err && o_rd == 0, "R7 write response", o_rd, 32'd0);
  endtask

  task automatic t_absent_read(input logic [2:0] sz, input logic [31:0] expd);
    access(1'b0, cfg_addr(5, 2, 8'h00), sz, 32'h0, 0);
    check(!o_fseen, "R3 absent read not forwarded", {31'd0, o_fseen}, 32'd0);
    check(o_got && !o_err && o_rd == expd, "R3 absent read ones", o_rd, expd);
    check(o_lat == exp_lat(), "R6 latency after acceptance", o_lat, exp_lat());
  endtask

  task automatic t_absent_write();
    access(1'b1, cfg_addr(0, 0, 8'h04), 3'd4, 32'h1234_5678, 0);
    check(!o_fseen, "R4 absent write not forwarded", {31'd0, o_fseen}, 32'd0);
    check(o_got && o_err && o_rd == 0, "R4 absent write error", {31'd0, o_err}, 32'd1);
  endtask

  task automatic t_bad_size(input logic wr, input logic [2:0] sz);
    access(wr, cfg_addr(3, 1, 8'h08), sz, 32'hAAAA_5555, 0);
    check(!o_fseen, "R5 bad size not forwarded", {29'd0, sz}, 32'd0);
    check(o_got && o_err && o_rd == 0, "R5 bad size error", {o_err, o_rd[30:0]}, 32'h8000_0000);
  endtask

  task automatic t_out_of_window(input logic [31:0] addr);
    access(1'b0, addr, 3'd4, 32'h0, 0);
    check(!o_fseen, "R11 outside window not forwarded", addr, 32'd0);
    check(o_got && o_err, "R11 outside window error", {31'd0, o_err}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; fwd_ready = 1'b0; fwd_rdata = '0;
    win_base = 32'h8A00_0123; win_mask = 32'hFFFF_0000; rsp_latency = 8'd1;

    t_reset_scan(8'd10, 1'b0);
    t_fwd_read(3, 1, 8'h40, 3'd4, 2);
    t_fwd_read(17, 5, 8'h0E, 3'd2, 0);
    t_fwd_read(3, 0, 8'hFC, 3'd1, 1);
    t_fwd_write();
    t_absent_read(3'd1, 32'h0000_00FF);
    t_absent_read(3'd2, 32'h0000_FFFF);
    t_absent_read(3'd4, 32'hFFFF_FFFF);
    t_absent_write();
    t_bad_size(1'b0, 3'd3);
    t_bad_size(1'b1, 3'd0);
    t_bad_size(1'b0, 3'd5);
    t_out_of_window(32'h8A01_0800);
    t_out_of_window(32'h89FF_FF00);

    rsp_latency = 8'd3;
    t_fwd_read(31, 7, 8'h20, 3'd4, 3);
    t_absent_read(3'd2, 32'h0000_FFFF);
    rsp_latency = 8'd0;
    t_fwd_read(17, 5, 8'h01, 3'd1, 0);
    t_absent_read(3'd4, 32'hFFFF_FFFF);

    t_reset_scan(8'd6, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule